// File: doc/BRIEF.md
# Dual-Rail Pipeline Register Stage with Completion Detection

This block is a clocked model of one register stage in a delay-insensitive dual-rail pipeline that carries dual-spacer traffic. Every bit travels on a pair of rails. A pair with exactly one rail high holds a data value. A pair with both rails equal is a spacer, and the spacer can have either polarity: both rails low or both rails high. The stage looks at the whole input bus on each clock and sorts it into one of four classes: complete data, complete all-low spacer, complete all-high spacer, or incomplete.

The next stage sends a request. High asks for data and low asks for a spacer. When a complete wavefront of the requested kind arrives, the stage captures it and updates its handshake toward the previous stage. The handshake goes low after data is captured, which asks for a spacer. It goes high after a spacer is captured, which asks for data. A sleep output follows the same rule and tells the downstream logic to hold its outputs at zero while the stage holds a spacer. Both spacer polarities pass through the stage unchanged, so an alternating spacer sequence reaches the next stage intact.

A protocol flag reports one illegal condition. It is raised when a pair shows both rails high while the stage waits for data and the last spacer it captured was all-low. Rails leaving an all-low spacer only ever rise toward a data value, so a pair with both rails high cannot occur legally at that point.

Top module: `dr_reg_stage`

## Requirements
- R1: Pair encoding with rails written (hi,lo): (1,0) is data one, (0,1) is data zero, (0,0) is the low spacer and (1,1) is the high spacer. A captured wavefront appears on out_hi/out_lo bit for bit as it was presented.
- R2: In the cycle after synchronous reset, out_hi and out_lo are all zero, prev_ack is 1, sleep is 1 and proto_err is 0.
- R3: When nxt_req is 1 and every pair is data, the next cycle shows that wavefront on the outputs, prev_ack at 0 and sleep at 0.
- R4: When nxt_req is 0 and every pair is the same spacer, either all (0,0) or all (1,1), the next cycle shows that spacer on the outputs, prev_ack at 1 and sleep at 1.
- R5: A bus that mixes data pairs and spacer pairs leaves out_hi, out_lo, prev_ack and sleep unchanged.
- R6: A complete wavefront of the kind that was not requested (data while nxt_req is 0, or a spacer while nxt_req is 1) leaves out_hi, out_lo, prev_ack and sleep unchanged.
- R7: A bus made only of spacer pairs that contains both (0,0) and (1,1) pairs counts as incomplete and leaves out_hi, out_lo, prev_ack and sleep unchanged.
- R8: prev_ack and sleep are always equal. Both are high exactly while the stage holds a spacer.
- R9: proto_err is 1 in the cycle after a wavefront that has at least one (1,1) pair and was presented while sleep was 1 and the most recently captured spacer was all-low (the reset state counts as all-low). In every other cycle proto_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hi | input | PAIRS | Rail one of each incoming pair |
| in_lo | input | PAIRS | Rail zero of each incoming pair |
| nxt_req | input | 1 | Request from next stage: 1 asks for data, 0 asks for spacer |
| prev_ack | output | 1 | Handshake to previous stage: 1 asks for data, 0 asks for spacer |
| sleep | output | 1 | Forces downstream logic to zero while a spacer is held |
| out_hi | output | PAIRS | Rail one of each held pair |
| out_lo | output | PAIRS | Rail zero of each held pair |
| proto_err | output | 1 | Illegal high-high pair seen while waiting for data after an all-low spacer |

## Verification
Capturing a spacer and raising the protocol flag can both happen on the same clock edge. This occurs when an all-high spacer arrives with nxt_req low while the stage sleeps after an all-low spacer. The bench reaches that case in its sweep by presenting all 64 patterns of a three-pair bus under each request value, starting from a stage that holds an all-low spacer, one that holds data, and one that holds an all-high spacer. For each pattern it checks that the output bus, the handshake and the flag all match its own model in the following cycle.

// File: rtl/dr_stage_pkg.sv
package dr_stage_pkg;

    // Classification of a whole dual-rail bus
    typedef enum logic [1:0] {
        WF_MIXED = 2'd0,
        WF_DATA  = 2'd1,
        WF_SPC0  = 2'd2,
        WF_SPC1  = 2'd3
    } wave_e;

    // Held state of the stage
    typedef struct packed {
        logic holds_spacer;
        logic last_spc_one;
    } stage_st_t;

    function automatic logic pair_is_data(input logic hi, input logic lo);
        return hi ^ lo;
    endfunction

    function automatic logic pair_is_spc0(input logic hi, input logic lo);
        return ~hi & ~lo;
    endfunction

    function automatic logic pair_is_spc1(input logic hi, input logic lo);
        return hi & lo;
    endfunction

endpackage

// File: rtl/dr_pair_scan.sv
module dr_pair_scan
    import dr_stage_pkg::*;
#(
    parameter int PAIRS = 8
) (
    input  logic [PAIRS-1:0] hi,
    input  logic [PAIRS-1:0] lo,
    output logic [PAIRS-1:0] is_data,
    output logic [PAIRS-1:0] is_spc0,
    output logic [PAIRS-1:0] is_spc1
);

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign is_data[g] = pair_is_data(hi[g], lo[g]);
        assign is_spc0[g] = pair_is_spc0(hi[g], lo[g]);
        assign is_spc1[g] = pair_is_spc1(hi[g], lo[g]);
    end

endmodule

// File: rtl/dr_wave_judge.sv
module dr_wave_judge
    import dr_stage_pkg::*;
#(
    parameter int PAIRS = 8
) (
    input  logic [PAIRS-1:0] is_data,
    input  logic [PAIRS-1:0] is_spc0,
    input  logic [PAIRS-1:0] is_spc1,
    output wave_e            wave,
    output logic             any_high_pair
);

    always_comb begin
        if (&is_data)
            wave = WF_DATA;
        else if (&is_spc0)
            wave = WF_SPC0;
        else if (&is_spc1)
            wave = WF_SPC1;
        else
            wave = WF_MIXED;
    end

    assign any_high_pair = |is_spc1;

endmodule

// File: rtl/dr_hold_reg.sv
module dr_hold_reg #(
    parameter int PAIRS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PAIRS-1:0] d_hi,
    input  logic [PAIRS-1:0] d_lo,
    output logic [PAIRS-1:0] q_hi,
    output logic [PAIRS-1:0] q_lo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_hi <= '0;
            q_lo <= '0;
        end else if (load) begin
            q_hi <= d_hi;
            q_lo <= d_lo;
        end
    end

endmodule

// File: rtl/dr_reg_stage.sv
module dr_reg_stage
    import dr_stage_pkg::*;
#(
    parameter int PAIRS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PAIRS-1:0] in_hi,
    input  logic [PAIRS-1:0] in_lo,
    input  logic             nxt_req,
    output logic             prev_ack,
    output logic             sleep,
    output logic [PAIRS-1:0] out_hi,
    output logic [PAIRS-1:0] out_lo,
    output logic             proto_err
);

    logic [PAIRS-1:0] is_data, is_spc0, is_spc1;
    wave_e            wave;
    logic             any_high_pair;
    logic             take_data, take_spc, load;
    stage_st_t        st;

    dr_pair_scan #(.PAIRS(PAIRS)) scan_i (
        .hi      (in_hi),
        .lo      (in_lo),
        .is_data (is_data),
        .is_spc0 (is_spc0),
        .is_spc1 (is_spc1)
    );

    dr_wave_judge #(.PAIRS(PAIRS)) judge_i (
        .is_data       (is_data),
        .is_spc0       (is_spc0),
        .is_spc1       (is_spc1),
        .wave          (wave),
        .any_high_pair (any_high_pair)
    );

    assign take_data = nxt_req && (wave == WF_DATA);
    assign take_spc  = !nxt_req && ((wave == WF_SPC0) || (wave == WF_SPC1));
    assign load      = take_data || take_spc;

    dr_hold_reg #(.PAIRS(PAIRS)) hold_i (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d_hi (in_hi),
        .d_lo (in_lo),
        .q_hi (out_hi),
        .q_lo (out_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st.holds_spacer <= 1'b1;
            st.last_spc_one <= 1'b0;
            proto_err       <= 1'b0;
        end else begin
            proto_err <= st.holds_spacer && !st.last_spc_one && any_high_pair;
            if (take_data) begin
                st.holds_spacer <= 1'b0;
            end else if (take_spc) begin
                st.holds_spacer <= 1'b1;
                st.last_spc_one <= (wave == WF_SPC1);
            end
        end
    end

    assign sleep    = st.holds_spacer;
    assign prev_ack = st.holds_spacer;

    // R3
    load_data_chk: assert property (@(posedge clk) disable iff (rst)
        (nxt_req && (&(in_hi ^ in_lo)))
        |=> (!sleep && !prev_ack && out_hi == $past(in_hi) && out_lo == $past(in_lo)));

    // R4
    load_spc_chk: assert property (@(posedge clk) disable iff (rst)
        (!nxt_req && ((in_hi == in_lo) && ((in_hi == '0) || (in_hi == '1))))
        |=> (sleep && prev_ack && out_hi == $past(in_hi) && out_lo == $past(in_lo)));

    // R5
    hold_mixed_chk: assert property (@(posedge clk) disable iff (rst)
        ((|(in_hi ^ in_lo)) && !(&(in_hi ^ in_lo)))
        |=> ($stable(out_hi) && $stable(out_lo) && $stable(sleep)));

    // R6
    ignore_other_chk: assert property (@(posedge clk) disable iff (rst)
        ((nxt_req && (in_hi == in_lo)) || (!nxt_req && (&(in_hi ^ in_lo))))
        |=> ($stable(out_hi) && $stable(out_lo) && $stable(prev_ack)));

    // R9
    err_origin_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(sleep) && $past(|(in_hi & in_lo))));

endmodule

// File: tb/dr_reg_stage_tb.sv
`timescale 1ns/1ps
module dr_reg_stage_tb_top;

    localparam int P = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [P-1:0] in_hi = '0, in_lo = '0;
    logic         nxt_req = 1'b0;
    logic         prev_ack, sleep, proto_err;
    logic [P-1:0] out_hi, out_lo;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    logic [P-1:0] m_hi, m_lo;
    logic         m_sleep, m_last1, m_err;

    always #4 clk = ~clk;

    dr_reg_stage #(.PAIRS(P)) dut_i (
        .clk(clk), .rst(rst), .in_hi(in_hi), .in_lo(in_lo), .nxt_req(nxt_req),
        .prev_ack(prev_ack), .sleep(sleep), .out_hi(out_hi), .out_lo(out_lo),
        .proto_err(proto_err)
    );

    task automatic check_state(input string tag);
        n_vec++;
        if (out_hi !== m_hi || out_lo !== m_lo || sleep !== m_sleep || prev_ack !== m_sleep) begin
            n_bad++;
            $display("FAIL %s: hi=%b lo=%b sleep=%b ack=%b expected hi=%b lo=%b sleep=%b ack=%b",
                     tag, out_hi, out_lo, sleep, prev_ack, m_hi, m_lo, m_sleep, m_sleep);
        end
        n_vec++;
        if (proto_err !== m_err) begin
            n_bad++;
            $display("FAIL R9: proto_err=%b expected %b", proto_err, m_err);
        end
    endtask

    // pattern: pair i rails {hi,lo} = pat[2i+1:2i]
    task automatic step(input logic req, input logic [2*P-1:0] pat);
        logic [P-1:0] h, l;
        logic all_d, all_0, all_1, any_11;
        string tag;
        for (int i = 0; i < P; i++) begin
            h[i] = pat[2*i+1];
            l[i] = pat[2*i];
        end
        all_d  = &(h ^ l);
        all_0  = (h == '0) && (l == '0);
        all_1  = (h == '1) && (l == '1);
        any_11 = |(h & l);
        m_err  = m_sleep && !m_last1 && any_11;
        if (req && all_d) begin
            tag = "R3 R1";
            m_hi = h; m_lo = l; m_sleep = 1'b0;
        end else if (!req && (all_0 || all_1)) begin
            tag = "R4 R1 R8";
            m_hi = h; m_lo = l; m_sleep = 1'b1; m_last1 = all_1;
        end else if (all_d || all_0 || all_1) begin
            tag = "R6";
        end else if ((h == l)) begin
            tag = "R7";
        end else begin
            tag = "R5";
        end
        in_hi = h; in_lo = l; nxt_req = req;
        @(posedge clk);
        @(negedge clk);
        check_state(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_hi = '0; m_lo = '0; m_sleep = 1'b1; m_last1 = 1'b0; m_err = 1'b0;
        check_state("R2");
        for (int prep = 0; prep < 3; prep++) begin
            for (int rq = 0; rq < 2; rq++) begin
                for (int pat = 0; pat < 64; pat++) begin
                    // bring stage into the chosen starting state
                    if (prep == 0) begin
                        step(1'b1, 6'b01_10_01);
                        step(1'b0, 6'b00_00_00);
                    end else if (prep == 1) begin
                        step(1'b0, 6'b11_11_11);
                        step(1'b1, 6'b10_01_10);
                    end else begin
                        step(1'b1, 6'b01_01_10);
                        step(1'b0, 6'b11_11_11);
                    end
                    step(rq[0], pat[5:0]);
                end
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule